// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block sits between a set of on-chip peripherals and a processor core. Each peripheral drives one request line and owns one enable bit. Each source also has a priority level, stored in a small register bank inside the block and written through a simple register write port. In every cycle the block takes the requests that are both raised and enabled and discards any source whose level is the reserved "disabled" code. From the rest it picks one winner: the lowest level wins, and on a tie the lowest source number wins.

The winner is then checked against two values that the processor drives. The first is a global interrupt enable flag. The second is the processor's current interrupt level mask. The block raises its accept output only when the flag is set and the winner's level is strictly below the mask. The winning source number and its level are presented whether or not the request is accepted. All outputs are registered, so they reflect the inputs one clock after those inputs are applied. Stacking registers, fetching vectors and the peripherals themselves belong to other blocks.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset every source level register holds 7, accept is 0, the winner number is 0 and the winner level is 7.
- R2: Source i is a candidate only when req[i] and en[i] are both 1. A source with only one of them set never wins.
- R3: Among candidates, the one with the numerically lowest 3-bit level wins. Level 0 is the most urgent.
- R4: Among candidates of equal level, the lowest source number wins.
- R5: A source whose level is 7 is never a candidate and is never accepted, even when its request and enable are set.
- R6: accept is 1 only if gie was 1 in the cycle the inputs were sampled. While gie is 0 the winner number and level are still reported.
- R7: accept is 1 only if the winner's level is strictly less than cur_mask. A level equal to the mask is not accepted.
- R8: accept, win_id and win_lvl are registered. They change on the first rising clock edge after the inputs change, and not before.
- R9: A clock edge with cfg_we=1 writes cfg_lvl into the level register of source cfg_idx. The level registers of all other sources keep their values.
- R10: When there is no candidate, the outputs after the next edge are accept=0, win_id=0 and win_lvl=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NSRC | Request line from each source |
| en | input | NSRC | Enable bit for each source |
| cfg_we | input | 1 | Level register write strobe |
| cfg_idx | input | IDXW | Source number written by cfg_we |
| cfg_lvl | input | LVLW | Level value to write |
| gie | input | 1 | Global interrupt enable from the processor |
| cur_mask | input | LVLW | Processor's current interrupt level mask |
| accept | output | 1 | Winner accepted for delivery |
| win_id | output | IDXW | Winning source number |
| win_lvl | output | LVLW | Level of the winning source |

## Verification
The bench builds the block with its default values: 16 sources and 3-bit levels. With these values both end sources (0 and 15) can be reached, along with the full level range from the most urgent code 0 to the reserved code 7. The tests cover mask edges where the winner's level is equal to, one below and above the mask. They also cover ties spread across distant source numbers, and a level rewrite that moves the win from one source to another.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NSRC = 16,
  parameter int LVLW = 3,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [LVLW-1:0] cfg_lvl,
  input  logic            gie,
  input  logic [LVLW-1:0] cur_mask,
  output logic            accept,
  output logic [IDXW-1:0] win_id,
  output logic [LVLW-1:0] win_lvl
);

  localparam logic [LVLW-1:0] LVL_OFF = '1;

  logic [LVLW-1:0] lvl_q [NSRC];
  logic [NSRC-1:0] cand;
  logic [IDXW-1:0] best_id;
  logic [LVLW-1:0] best_lvl;
  logic            found;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        lvl_q[g] <= LVL_OFF;
      else if (cfg_we && cfg_idx == IDXW'(g))
        lvl_q[g] <= cfg_lvl;

    assign cand[g] = req[g] & en[g] & (lvl_q[g] != LVL_OFF);
  end

  always_comb begin
    best_id  = '0;
    best_lvl = LVL_OFF;
    for (int i = 0; i < NSRC; i++)
      if (cand[i] && lvl_q[i] < best_lvl) begin
        best_id  = IDXW'(i);
        best_lvl = lvl_q[i];
      end
  end

  assign found = |cand;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      accept  <= 1'b0;
      win_id  <= '0;
      win_lvl <= LVL_OFF;
    end else begin
      accept  <= found & gie & (best_lvl < cur_mask);
      win_id  <= best_id;
      win_lvl <= best_lvl;
    end

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int NSRC = 16,
  parameter int LVLW = 3,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req,
  input logic [NSRC-1:0] en,
  input logic            gie,
  input logic [LVLW-1:0] cur_mask,
  input logic            accept,
  input logic [IDXW-1:0] win_id,
  input logic [LVLW-1:0] win_lvl
);

  AST_ACCEPT_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(gie)); // R6

  AST_ACCEPT_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (win_lvl < $past(cur_mask))); // R7

  AST_ACCEPT_LIVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((($past(req) & $past(en)) >> win_id) & NSRC'(1)) != '0); // R2

  AST_NO_OFF_LEVEL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (win_lvl != {LVLW{1'b1}})); // R5

  AST_IDLE_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req & en) == '0) |-> (!accept && win_id == '0 && win_lvl == {LVLW{1'b1}})); // R10

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.NSRC(NSRC), .LVLW(LVLW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .en(en), .gie(gie), .cur_mask(cur_mask),
  .accept(accept), .win_id(win_id), .win_lvl(win_lvl)
);

// File: tb/irq_level_arbiter_test.sv
module irq_level_arbiter_test;
  localparam int NSRC = 16;
  localparam int LVLW = 3;
  localparam int IDXW = 4;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [NSRC-1:0] req = '0;
  logic [NSRC-1:0] en = '0;
  logic            cfg_we = 0;
  logic [IDXW-1:0] cfg_idx = '0;
  logic [LVLW-1:0] cfg_lvl = '0;
  logic            gie = 0;
  logic [LVLW-1:0] cur_mask = '0;
  logic            accept;
  logic [IDXW-1:0] win_id;
  logic [LVLW-1:0] win_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_level_arbiter #(.NSRC(NSRC), .LVLW(LVLW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .en(en), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .gie(gie), .cur_mask(cur_mask),
    .accept(accept), .win_id(win_id), .win_lvl(win_lvl)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(string rq, logic a, logic [IDXW-1:0] id, logic [LVLW-1:0] lv);
    n_chk++;
    if (accept !== a || win_id !== id || win_lvl !== lv) begin
      n_bad++;
      $display("FAIL %s: got acc=%0b id=%0d lvl=%0d, expected acc=%0b id=%0d lvl=%0d",
               rq, accept, win_id, win_lvl, a, id, lv);
    end
  endtask

  task automatic wr_lvl(int idx, int lv);
    cfg_we  = 1;
    cfg_idx = IDXW'(idx);
    cfg_lvl = LVLW'(lv);
    step();
    cfg_we  = 0;
  endtask

  task automatic t_reset();
    expect_out("R1 reset outputs", 1'b0, 4'd0, 3'd7);
    req = '1; en = '1; gie = 1; cur_mask = 3'd7;
    step();
    expect_out("R1 levels reset to 7", 1'b0, 4'd0, 3'd7);
    req = '0; en = '0;
    step();
  endtask

  task automatic t_gate();
    wr_lvl(9, 2);
    req = 16'h0200; en = 16'h0000;
    step();
    expect_out("R2 req without enable", 1'b0, 4'd0, 3'd7);
    req = 16'h0000; en = 16'h0200;
    step();
    expect_out("R2 enable without req", 1'b0, 4'd0, 3'd7);
    req = 16'h0200;
    step();
    expect_out("R2 req and enable", 1'b1, 4'd9, 3'd2);
  endtask

  task automatic t_priority();
    wr_lvl(3, 5);
    req = 16'h0208; en = 16'h0208;
    step();
    expect_out("R3 lower level wins", 1'b1, 4'd9, 3'd2);
    wr_lvl(15, 0);
    req = 16'h8208; en = 16'h8208;
    step();
    expect_out("R3 level 0 at top source wins", 1'b1, 4'd15, 3'd0);
  endtask

  task automatic t_tie();
    wr_lvl(12, 2);
    req = 16'h1208; en = 16'h1208;
    step();
    expect_out("R4 tie lowest index 9", 1'b1, 4'd9, 3'd2);
    wr_lvl(4, 2);
    req = 16'h1218; en = 16'h1218;
    step();
    expect_out("R4 tie lowest index 4", 1'b1, 4'd4, 3'd2);
  endtask

  task automatic t_off_level();
    req = 16'h0001; en = 16'h0001; gie = 1; cur_mask = 3'd7;
    step();
    expect_out("R5 level 7 not a candidate", 1'b0, 4'd0, 3'd7);
    req = 16'h0009; en = 16'h0009;
    step();
    expect_out("R5 level 7 loses to level 5", 1'b1, 4'd3, 3'd5);
  endtask

  task automatic t_gie();
    req = 16'h0010; en = 16'h0010; cur_mask = 3'd7; gie = 0;
    step();
    expect_out("R6 gie low blocks accept", 1'b0, 4'd4, 3'd2);
    gie = 1;
    step();
    expect_out("R6 gie high accepts", 1'b1, 4'd4, 3'd2);
  endtask

  task automatic t_mask();
    req = 16'h0010; en = 16'h0010; gie = 1;
    cur_mask = 3'd2;
    step();
    expect_out("R7 level equal to mask", 1'b0, 4'd4, 3'd2);
    cur_mask = 3'd3;
    step();
    expect_out("R7 level one below mask", 1'b1, 4'd4, 3'd2);
    cur_mask = 3'd0;
    step();
    expect_out("R7 mask 0 blocks all", 1'b0, 4'd4, 3'd2);
    req = 16'h8000; en = 16'h8000; cur_mask = 3'd1;
    step();
    expect_out("R7 level 0 under mask 1", 1'b1, 4'd15, 3'd0);
  endtask

  task automatic t_latency();
    req = '0; en = '0; gie = 1; cur_mask = 3'd7;
    step();
    expect_out("R10 idle", 1'b0, 4'd0, 3'd7);
    req = 16'h0200; en = 16'h0200;
    #3;
    expect_out("R8 no change before edge", 1'b0, 4'd0, 3'd7);
    step();
    expect_out("R8 update after one edge", 1'b1, 4'd9, 3'd2);
  endtask

  task automatic t_write();
    req = 16'h1200; en = 16'h1200; gie = 1; cur_mask = 3'd7;
    wr_lvl(9, 7);
    step();
    expect_out("R9 rewrite moves win to 12", 1'b1, 4'd12, 3'd2);
    wr_lvl(0, 1);
    req = 16'h1219; en = 16'h1219;
    step();
    expect_out("R9 source 0 level 1", 1'b1, 4'd0, 3'd1);
    req = 16'h1018; en = 16'h1018;
    step();
    expect_out("R9 others unchanged", 1'b1, 4'd4, 3'd2);
    req = '0; en = '0;
    step();
    expect_out("R10 idle after activity", 1'b0, 4'd0, 3'd7);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    step();
    t_reset();
    t_gate();
    t_priority();
    t_tie();
    t_off_level();
    t_gie();
    t_mask();
    t_latency();
    t_write();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule